// File: doc/BRIEF.md
# DLX Integer ALU with Status Flags

This block is the integer arithmetic and logic unit of a DLX-style pipeline. Two 32-bit operands and a 4-bit function code enter, and the selected operation's 32-bit result leaves in the same cycle. Three flags leave with it: zero, negative and overflow.

The ALU computes signed and unsigned add and subtract. The two signedness classes use different overflow rules. It also computes bitwise AND, OR and XOR, and logical left, logical right and arithmetic right shifts. A shift uses only the five lowest bits of the second operand as its distance.

The block holds no state. Its operand latches, the instruction decode and the register file sit outside it. Internally, a small decoder turns the function code into a struct of strobes, and a datapath acts on those strobes.

Top module: `dlxAlu`

## Requirements
- R1: Function codes 0 (signed add), 1 (unsigned add), 2 (signed subtract) and 3 (unsigned subtract) produce opA+opB or opA-opB modulo 2^32 on `result`.
- R2: For codes 0 and 2, `ovfFlag` is 1 exactly when the true two's-complement sum or difference lies outside -2^31 .. 2^31-1.
- R3: For code 1, `ovfFlag` is the carry out of bit 31. For code 3, `ovfFlag` is 1 exactly when opB is greater than opA as unsigned numbers (a borrow).
- R4: Codes 4, 5 and 6 produce the bitwise AND, OR and XOR of the operands, with `ovfFlag` at 0.
- R5: Code 7 shifts opA left by opB[4:0] places and fills with zeros. Bits opB[31:5] have no effect.
- R6: Code 8 shifts opA right by opB[4:0] and fills with zeros. Code 9 shifts opA right by opB[4:0] and fills with copies of opA[31]. Both force `ovfFlag` to 0.
- R7: Codes 10 to 15 are unused. They give `result` = 0 and `ovfFlag` = 0.
- R8: `zeroFlag` is 1 exactly when `result` is all zeros.
- R9: `negFlag` equals `result[31]` for every function code.
- R10: The block is purely combinational. A change on any input appears on the outputs within the same cycle, and no clock edge is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand; the value that is shifted |
| opB | input | 32 | Second operand; its low five bits give the shift distance |
| funcSel | input | 4 | Function code, encoded as listed in R1 to R7 |
| result | output | 32 | Result of the selected operation |
| zeroFlag | output | 1 | Result is all zeros |
| negFlag | output | 1 | Sign bit of the result |
| ovfFlag | output | 1 | Overflow of the selected add or subtract; 0 otherwise |

## Verification
The hardest case is one where the signed and unsigned overflow rules disagree for the same operand pair. An example is 0x7FFFFFFF+1, which overflows as signed but not as unsigned. A pair on its own cannot reveal whether the decoder picked the wrong rule, so the vector table applies the same boundary pairs to both the signed and the unsigned codes. These pairs are 0x7FFFFFFF+1, 0x80000000-1, 0xFFFFFFFF+1 and 0-1, each with the expected flag written down per code. Shift vectors set bits above position 4 in opB, to show that only the five low bits steer the shifter. A pseudo-random sweep then compares unsigned sums, carries and signed differences against arithmetic done in the bench.

// File: rtl/dlxAluPkg.sv
package dlxAluPkg;

  localparam int DATA_W  = 32;
  localparam int FUNC_W  = 4;

  typedef enum logic [FUNC_W-1:0] {
    FN_ADD  = 4'd0,
    FN_ADDU = 4'd1,
    FN_SUB  = 4'd2,
    FN_SUBU = 4'd3,
    FN_AND  = 4'd4,
    FN_OR   = 4'd5,
    FN_XOR  = 4'd6,
    FN_SLL  = 4'd7,
    FN_SRL  = 4'd8,
    FN_SRA  = 4'd9
  } aluFunc_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logicSel_e;

  // Strobes passed from the decoder to the datapath.
  typedef struct packed {
    logic      useArith;
    logic      subtract;
    logic      signedOvf;
    logic      useLogic;
    logicSel_e logicSel;
    logic      useShift;
    logic      shiftLeft;
    logic      shiftArith;
  } aluStrobes_t;

endpackage

// File: rtl/dlxAluCtrl.sv
module dlxAluCtrl
  import dlxAluPkg::*;
#(
  parameter int FUNC_W = dlxAluPkg::FUNC_W
) (
  input  logic [FUNC_W-1:0] funcSel,
  output aluStrobes_t       strobes
);

  always_comb begin
    strobes = '0;
    case (funcSel)
      FN_ADD:  begin strobes.useArith = 1'b1; strobes.signedOvf = 1'b1; end
      FN_ADDU: begin strobes.useArith = 1'b1; end
      FN_SUB:  begin strobes.useArith = 1'b1; strobes.subtract = 1'b1;
                     strobes.signedOvf = 1'b1; end
      FN_SUBU: begin strobes.useArith = 1'b1; strobes.subtract = 1'b1; end
      FN_AND:  begin strobes.useLogic = 1'b1; strobes.logicSel = LG_AND; end
      FN_OR:   begin strobes.useLogic = 1'b1; strobes.logicSel = LG_OR;  end
      FN_XOR:  begin strobes.useLogic = 1'b1; strobes.logicSel = LG_XOR; end
      FN_SLL:  begin strobes.useShift = 1'b1; strobes.shiftLeft = 1'b1; end
      FN_SRL:  begin strobes.useShift = 1'b1; end
      FN_SRA:  begin strobes.useShift = 1'b1; strobes.shiftArith = 1'b1; end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/dlxAluAddSub.sv
module dlxAluAddSub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  input  logic              subtract,
  output logic [DATA_W-1:0] sum,
  output logic              signedOvf,
  output logic              unsignedOvf
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] bInv;
  logic [DATA_W:0]   wide;
  logic              carryOut;

  always_comb begin
    bInv     = inB ^ {DATA_W{subtract}};
    wide     = {1'b0, inA} + {1'b0, bInv} + {{DATA_W{1'b0}}, subtract};
    sum      = wide[MSB:0];
    carryOut = wide[DATA_W];
    // Operands of like sign yielding a result of the other sign.
    signedOvf   = (inA[MSB] == bInv[MSB]) && (sum[MSB] != inA[MSB]);
    // Add: carry out. Subtract: borrow, i.e. no carry out.
    unsignedOvf = subtract ? ~carryOut : carryOut;
  end

endmodule

// File: rtl/dlxAluShifter.sv
module dlxAluShifter #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  inA,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic               shiftLeft,
  input  logic               shiftArith,
  output logic [DATA_W-1:0]  shifted
);

  localparam int MSB = DATA_W - 1;

  function automatic logic [DATA_W-1:0] bitFlip(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[MSB-i];
    return r;
  endfunction

  logic [DATA_W-1:0] stage [0:SHAMT_W];
  logic              fillBit;

  // Left shifts reuse the right shifter on a bit-reversed word.
  always_comb begin
    fillBit  = shiftArith & ~shiftLeft & inA[MSB];
    stage[0] = shiftLeft ? bitFlip(inA) : inA;
  end

  for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
    localparam int DIST = 1 << s;
    always_comb begin
      if (shamt[s])
        stage[s+1] = {{DIST{fillBit}}, stage[s][MSB:DIST]};
      else
        stage[s+1] = stage[s];
    end
  end

  always_comb shifted = shiftLeft ? bitFlip(stage[SHAMT_W]) : stage[SHAMT_W];

endmodule

// File: rtl/dlxAluDatapath.sv
module dlxAluDatapath
  import dlxAluPkg::*;
#(
  parameter int DATA_W  = dlxAluPkg::DATA_W,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluStrobes_t       strobes,
  output logic [DATA_W-1:0] result,
  output logic              zeroFlag,
  output logic              negFlag,
  output logic              ovfFlag
);

  logic [DATA_W-1:0] arithRes, logicRes, shiftRes;
  logic              sOvf, uOvf;

  dlxAluAddSub #(.DATA_W(DATA_W)) uAddSub (
    .inA        (opA),
    .inB        (opB),
    .subtract   (strobes.subtract),
    .sum        (arithRes),
    .signedOvf  (sOvf),
    .unsignedOvf(uOvf)
  );

  dlxAluShifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) uShift (
    .inA       (opA),
    .shamt     (opB[SHAMT_W-1:0]),
    .shiftLeft (strobes.shiftLeft),
    .shiftArith(strobes.shiftArith),
    .shifted   (shiftRes)
  );

  always_comb begin
    case (strobes.logicSel)
      LG_AND:  logicRes = opA & opB;
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      default: logicRes = '0;
    endcase
  end

  // Strobes are one-hot or all clear, so an AND-OR mux suffices.
  always_comb begin
    result = ({DATA_W{strobes.useArith}} & arithRes)
           | ({DATA_W{strobes.useLogic}} & logicRes)
           | ({DATA_W{strobes.useShift}} & shiftRes);
    zeroFlag = ~|result;
    negFlag  = result[DATA_W-1];
    ovfFlag  = strobes.useArith & (strobes.signedOvf ? sOvf : uOvf);
  end

endmodule

// File: rtl/dlxAlu.sv
module dlxAlu
  import dlxAluPkg::*;
#(
  parameter int DATA_W = dlxAluPkg::DATA_W,
  parameter int FUNC_W = dlxAluPkg::FUNC_W
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [FUNC_W-1:0] funcSel,
  output logic [DATA_W-1:0] result,
  output logic              zeroFlag,
  output logic              negFlag,
  output logic              ovfFlag
);

  localparam int SHAMT_W = $clog2(DATA_W);

  aluStrobes_t strobes;

  dlxAluCtrl #(.FUNC_W(FUNC_W)) uCtrl (
    .funcSel(funcSel),
    .strobes(strobes)
  );

  dlxAluDatapath #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) uPath (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .zeroFlag(zeroFlag),
    .negFlag (negFlag),
    .ovfFlag (ovfFlag)
  );

endmodule

// File: rtl/dlxAluChecker.sv
module dlxAluChecker #(
  parameter int DATA_W = 32,
  parameter int FUNC_W = 4
) (
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [FUNC_W-1:0] funcSel,
  input logic [DATA_W-1:0] result,
  input logic              zeroFlag,
  input logic              negFlag,
  input logic              ovfFlag
);

  logic              known;
  logic [DATA_W:0]   wideSum;

  always_comb begin
    known   = !$isunknown({opA, opB, funcSel, result, zeroFlag, negFlag, ovfFlag});
    wideSum = {1'b0, opA} + {1'b0, opB};
    p_zero_flag_r8:     assert (!known || (zeroFlag == (result == '0)));
    p_neg_flag_r9:      assert (!known || (negFlag == result[DATA_W-1]));
    p_addu_sum_r1:      assert (!known || funcSel != 4'd1 || result == wideSum[DATA_W-1:0]);
    p_addu_carry_r3:    assert (!known || funcSel != 4'd1 || ovfFlag == wideSum[DATA_W]);
    p_subu_borrow_r3:   assert (!known || funcSel != 4'd3 || ovfFlag == (opB > opA));
    p_logic_no_ovf_r4:  assert (!known || !(funcSel >= 4'd4 && funcSel <= 4'd6) || !ovfFlag);
    p_shift_no_ovf_r6:  assert (!known || !(funcSel >= 4'd7 && funcSel <= 4'd9) || !ovfFlag);
    p_unused_quiet_r7:  assert (!known || funcSel < 4'd10 || (result == '0 && !ovfFlag));
  end

endmodule

bind dlxAlu dlxAluChecker #(.DATA_W(DATA_W), .FUNC_W(FUNC_W)) uChk (
  .opA     (opA),
  .opB     (opB),
  .funcSel (funcSel),
  .result  (result),
  .zeroFlag(zeroFlag),
  .negFlag (negFlag),
  .ovfFlag (ovfFlag)
);

// File: tb/dlxAlu_test.sv
`timescale 1ns/1ps
module dlxAlu_test;

  typedef struct packed {
    logic [3:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] r;
    logic        z;
    logic        n;
    logic        v;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1, 1'b1}, // R2
    '{4'd1, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0, 1'b1}, // R3
    '{4'd2, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b0, 1'b1}, // R2
    '{4'd3, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b0, 1'b1, 1'b1}, // R3
    '{4'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R1 R8
    '{4'd1, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1, 1'b0}, // R3 R9
    '{4'd2, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b0, 1'b1, 1'b0}, // R2
    '{4'd3, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R3
    '{4'd3, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd0, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b0, 1'b1}, // R2
    '{4'd4, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0, 1'b1, 1'b0}, // R4
    '{4'd5, 32'h0000000F, 32'h000000F0, 32'h000000FF, 1'b0, 1'b0, 1'b0}, // R4
    '{4'd6, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R4
    '{4'd4, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b1, 1'b0}, // R4
    '{4'd7, 32'h00000001, 32'h0000003F, 32'h80000000, 1'b0, 1'b1, 1'b0}, // R5
    '{4'd7, 32'h12345678, 32'h00000020, 32'h12345678, 1'b0, 1'b0, 1'b0}, // R5
    '{4'd8, 32'h80000000, 32'h00000004, 32'h08000000, 1'b0, 1'b0, 1'b0}, // R6
    '{4'd9, 32'h80000000, 32'h00000004, 32'hF8000000, 1'b0, 1'b1, 1'b0}, // R6
    '{4'd9, 32'h7FFFFFFF, 32'h0000001F, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R6
    '{4'd8, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0, 1'b0}, // R6
    '{4'd15, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R7
    '{4'd10, 32'h7FFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0, 1'b0}  // R7
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA, opB, result;
  logic [3:0]  funcSel;
  logic        zeroFlag, negFlag, ovfFlag;
  int          nChecks = 0;
  int          nFails  = 0;
  bit          done    = 1'b0;

  always #4 clk = ~clk;

  dlxAlu uut (
    .opA(opA), .opB(opB), .funcSel(funcSel),
    .result(result), .zeroFlag(zeroFlag), .negFlag(negFlag), .ovfFlag(ovfFlag)
  );

  task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    funcSel = f; opA = a; opB = b;
    #1;
  endtask

  initial begin
    opA = '0; opB = '0; funcSel = 4'd0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // Idle state with all-zero inputs: signed add of zeros.
    apply(4'd0, 32'h0, 32'h0);
    check("R8 idle", {result, zeroFlag, negFlag, ovfFlag}, {32'h0, 1'b1, 1'b0, 1'b0});

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].fn, VECS[i].a, VECS[i].b);
      check($sformatf("R1-table vec %0d fn %0d", i, VECS[i].fn),
            {result, zeroFlag, negFlag, ovfFlag},
            {VECS[i].r, VECS[i].z, VECS[i].n, VECS[i].v});
    end

    // R5: high bits of opB ignored for shifts.
    apply(4'd7, 32'h00000003, 32'hFFFFFFE2);
    check("R5 high shamt bits", {result, zeroFlag, negFlag, ovfFlag}, {32'h0000000C, 3'b000});

    // R10: change inputs mid-cycle with no clock edge between.
    @(negedge clk);
    funcSel = 4'd5; opA = 32'h00000100; opB = 32'h00000001;
    #1;
    check("R10 first", {result, zeroFlag, negFlag, ovfFlag}, {32'h00000101, 3'b000});
    opA = 32'h80000000;
    #1;
    check("R10 follow", {result, zeroFlag, negFlag, ovfFlag}, {32'h80000001, 3'b010});

    // R1 R2 R3: sweep with bench arithmetic.
    begin
      logic [31:0] a = 32'h1234ABCD;
      logic [31:0] b = 32'h9E3779B9;
      for (int k = 0; k < 200; k++) begin
        logic [32:0] s;
        logic [31:0] d;
        logic        sv;
        a = a ^ (a << 13); a = a ^ (a >> 17); a = a ^ (a << 5);
        b = b ^ (b << 7);  b = b ^ (b >> 9);  b = b ^ (b << 8);
        s = {1'b0, a} + {1'b0, b};
        apply(4'd1, a, b);
        check("R1 R3 addu sweep", {result, zeroFlag, negFlag, ovfFlag},
              {s[31:0], s[31:0] == 32'h0, s[31], s[32]});
        d  = a - b;
        sv = ($signed({a[31], a}) - $signed({b[31], b})) != $signed({d[31], d});
        apply(4'd2, a, b);
        check("R1 R2 sub sweep", {result, zeroFlag, negFlag, ovfFlag},
              {d, d == 32'h0, d[31], sv});
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule